// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block sits between a running clock and a set of clock output pins. Each plain output is started or stopped by its own enable bit, and every output can be stopped at once by a power-down request. All decisions are taken on the falling edge of the source clock. A change therefore only takes effect while the clock is low, so a stop never cuts a high pulse short and a start never begins with a partial one. A stopped plain output rests low.

The differential CPU pair has its own enable bit and a richer set of states. When it runs, the complement output is the inverse of the true output. Under power-down in processor mode 1, a park-style bit chooses between two resting states: true high with complement low, or both outputs released to high impedance. In processor mode 0 the park-style bit has no effect, and power-down simply drives both outputs low.

Each plain output has two states: `GS_OFF` and `GS_RUN`. The pair has four: `PS_OFF`, `PS_RUN`, `PS_PARK_HI` and `PS_PARK_Z`. Every transition is taken on a falling edge. Power-down leads to `GS_OFF` for the plain outputs. For the pair it leads to `PS_PARK_HI` or `PS_PARK_Z` in mode 1, and to `PS_OFF` in mode 0. When power-down is absent, the enable bit chooses between run and off. Reset forces `GS_OFF` and `PS_OFF`.

Top module: `clk_stop_gate`

## Requirements
- R1: With `pwr_dn`=0 and `out_en[i]`=1, `clk_out[i]` follows `clk_in` from the first falling edge that samples the enable.
- R2: A stopped plain output (enable 0 or power-down) is held at logic low.
- R3: Gating state changes only on falling edges of `clk_in`, so every high phase of an output is either complete or absent.
- R4: With `cpu_mode`=1, `park_z`=0 and `pwr_dn`=1, the pair settles at `cpu_t`=1, `cpu_c`=0, `cpu_oe`=1.
- R5: With `cpu_mode`=1, `park_z`=1 and `pwr_dn`=1, `cpu_oe`=0 (both pair outputs at high impedance).
- R6: With `cpu_mode`=0, `park_z` is ignored: under power-down the pair sits at `cpu_t`=0, `cpu_c`=0, `cpu_oe`=1.
- R7: When the pair runs, `cpu_c` is the inverse of `cpu_t`, and `cpu_oe`=1.
- R8: `pwr_dn`=1 stops every plain output, whatever its enable bit.
- R9: While `rst_n`=0, all outputs are low and `cpu_oe`=1. Inputs take effect at the first falling edge after reset is released.
- R10: With `pwr_dn`=0 and `cpu_en`=0, the pair sits at `cpu_t`=0, `cpu_c`=0, `cpu_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | N_OUT | Per-output enable bits for the plain outputs |
| cpu_en | input | 1 | Enable bit for the CPU pair |
| pwr_dn | input | 1 | Power-down request, active high |
| cpu_mode | input | 1 | Processor mode flag (1 allows the park-style choice) |
| park_z | input | 1 | Park style in mode 1: 0 = true high/complement low, 1 = high impedance |
| clk_out | output | N_OUT | Gated plain clock outputs |
| cpu_t | output | 1 | CPU pair true output |
| cpu_c | output | 1 | CPU pair complement output |
| cpu_oe | output | 1 | Output-enable for the CPU pair drivers (0 = high impedance) |

## Verification
Some properties are checked on every cycle. The gating state may never move while the clock is high. Each park state must follow power-down in the right mode. The pair must stay complementary while running. Every stopped output must read low at the next falling edge.

Other behaviour can only be shown by the bench's scenarios, where a model predicts each output in both clock phases. Those scenarios cover:
- the full high phase seen after each start and before each stop;
- the reset values and the first edge after reset;
- random mixes of enables with power-down across both processor modes.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef enum logic [0:0] {
        GS_OFF = 1'b0,
        GS_RUN = 1'b1
    } gate_st_t;

    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_RUN     = 2'd1,
        PS_PARK_HI = 2'd2,
        PS_PARK_Z  = 2'd3
    } pair_st_t;

endpackage

// File: rtl/clk_gate_cell.sv
module clk_gate_cell
    import clk_stop_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    input  logic pwr_dn,
    output logic clk_out
);

    gate_st_t st_q;
    gate_st_t st_d;

    // Next-state choice: power-down wins over the enable bit
    always_comb begin
        unique case (st_q)
            GS_RUN:  st_d = (pwr_dn || !en) ? GS_OFF : GS_RUN;
            GS_OFF:  st_d = (!pwr_dn && en) ? GS_RUN : GS_OFF;
            default: st_d = GS_OFF;
        endcase
    end

    // State register updates only while the clock is low
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) st_q <= GS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            GS_RUN:  clk_out = clk_in;
            GS_OFF:  clk_out = 1'b0;
            default: clk_out = 1'b0;
        endcase
    end

    // R3: gating state may only move while clk_in is low
    always @(st_q) begin
        if (rst_n) begin
            p_change_low_r3: assert (!clk_in);
        end
    end

    // R2: a stop request leaves the output low at the next falling edge
    p_stop_low_r2: assert property (@(negedge clk_in) disable iff (!rst_n)
        (pwr_dn || !en) |=> (clk_out == 1'b0));

endmodule

// File: rtl/clk_pair_gate.sv
module clk_pair_gate
    import clk_stop_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    input  logic pwr_dn,
    input  logic cpu_mode,
    input  logic park_z,
    output logic cpu_t,
    output logic cpu_c,
    output logic cpu_oe
);

    pair_st_t st_q;
    pair_st_t st_d;
    pair_st_t pd_target;

    // Resting state under power-down depends on mode; park_z matters in mode 1 only
    always_comb begin
        if (cpu_mode) pd_target = park_z ? PS_PARK_Z : PS_PARK_HI;
        else          pd_target = PS_OFF;
    end

    always_comb begin
        unique case (st_q)
            PS_RUN:     st_d = pwr_dn ? pd_target : (en ? PS_RUN : PS_OFF);
            PS_OFF:     st_d = pwr_dn ? pd_target : (en ? PS_RUN : PS_OFF);
            PS_PARK_HI: st_d = pwr_dn ? pd_target : (en ? PS_RUN : PS_OFF);
            PS_PARK_Z:  st_d = pwr_dn ? pd_target : (en ? PS_RUN : PS_OFF);
            default:    st_d = PS_OFF;
        endcase
    end

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) st_q <= PS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            PS_RUN: begin
                cpu_t  = clk_in;
                cpu_c  = ~clk_in;
                cpu_oe = 1'b1;
            end
            PS_PARK_HI: begin
                cpu_t  = 1'b1;
                cpu_c  = 1'b0;
                cpu_oe = 1'b1;
            end
            PS_PARK_Z: begin
                cpu_t  = 1'b0;
                cpu_c  = 1'b0;
                cpu_oe = 1'b0;
            end
            PS_OFF: begin
                cpu_t  = 1'b0;
                cpu_c  = 1'b0;
                cpu_oe = 1'b1;
            end
            default: begin
                cpu_t  = 1'b0;
                cpu_c  = 1'b0;
                cpu_oe = 1'b1;
            end
        endcase
    end

    // R3: pair state may only move while clk_in is low
    always @(st_q) begin
        if (rst_n) begin
            p_pair_low_r3: assert (!clk_in);
        end
    end

    p_park_hi_r4: assert property (@(negedge clk_in) disable iff (!rst_n)
        (pwr_dn && cpu_mode && !park_z) |=> (cpu_t && !cpu_c && cpu_oe));

    p_park_z_r5: assert property (@(negedge clk_in) disable iff (!rst_n)
        (pwr_dn && cpu_mode && park_z) |=> !cpu_oe);

    p_mode0_r6: assert property (@(negedge clk_in) disable iff (!rst_n)
        (pwr_dn && !cpu_mode) |=> (!cpu_t && !cpu_c && cpu_oe));

    p_inverse_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st_q == PS_RUN) |-> ((cpu_c == ~cpu_t) && cpu_oe));

    p_pair_off_r10: assert property (@(negedge clk_in) disable iff (!rst_n)
        (!pwr_dn && !en) |=> (!cpu_t && !cpu_c && cpu_oe));

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_OUT = 8
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] out_en,
    input  logic             cpu_en,
    input  logic             pwr_dn,
    input  logic             cpu_mode,
    input  logic             park_z,
    output logic [N_OUT-1:0] clk_out,
    output logic             cpu_t,
    output logic             cpu_c,
    output logic             cpu_oe
);

    localparam logic [N_OUT-1:0] ALL_LOW = '0;

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_cell
        clk_gate_cell u_cell (
            .clk_in  (clk_in),
            .rst_n   (rst_n),
            .en      (out_en[gi]),
            .pwr_dn  (pwr_dn),
            .clk_out (clk_out[gi])
        );
    end

    clk_pair_gate u_pair (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .en       (cpu_en),
        .pwr_dn   (pwr_dn),
        .cpu_mode (cpu_mode),
        .park_z   (park_z),
        .cpu_t    (cpu_t),
        .cpu_c    (cpu_c),
        .cpu_oe   (cpu_oe)
    );

    // R8: power-down silences every plain output regardless of enables
    p_pd_all_low_r8: assert property (@(negedge clk_in) disable iff (!rst_n)
        pwr_dn |=> (clk_out == ALL_LOW));

endmodule

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;

    localparam int N = 8;

    logic         clk_in = 1'b0;
    logic         rst_n;
    logic [N-1:0] out_en;
    logic         cpu_en, pwr_dn, cpu_mode, park_z;
    logic [N-1:0] clk_out;
    logic         cpu_t, cpu_c, cpu_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_run;
    int           m_pair;
    logic [N-1:0] prev_run;

    always #2 clk_in = ~clk_in;

    clk_stop_gate #(.N_OUT(N)) uut (
        .clk_in(clk_in), .rst_n(rst_n), .out_en(out_en), .cpu_en(cpu_en),
        .pwr_dn(pwr_dn), .cpu_mode(cpu_mode), .park_z(park_z),
        .clk_out(clk_out), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe)
    );

    // Pair codes: 0 running, 1 off low, 2 parked true-high, 3 high impedance
    function automatic int exp_pair(bit pd, bit en, bit mode, bit pz);
        if (pd) return mode ? (pz ? 3 : 2) : 1;
        return en ? 0 : 1;
    endfunction

    function automatic logic [N-1:0] exp_run(bit pd, logic [N-1:0] en);
        return pd ? '0 : en;
    endfunction

    function automatic string pair_tag(int code, bit pd);
        case (code)
            0: return "R7";
            2: return "R4";
            3: return "R5";
            default: return pd ? "R6" : "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_low();
        string t;
        t = pwr_dn ? "R8" : "R2";
        chk(t, 32'(clk_out), 32'(0));
        t = pair_tag(m_pair, pwr_dn);
        chk(t, {29'd0, cpu_t, cpu_c, cpu_oe},
            {29'd0, (m_pair == 2), (m_pair == 0), (m_pair != 3)});
    endtask

    task automatic check_high();
        string t;
        if (prev_run != m_run) t = "R3";
        else if (pwr_dn)       t = "R8";
        else                   t = "R1";
        chk(t, 32'(clk_out), 32'(m_run));
        t = pair_tag(m_pair, pwr_dn);
        chk(t, {29'd0, cpu_t, cpu_c, cpu_oe},
            {29'd0, (m_pair == 0 || m_pair == 2), 1'b0, (m_pair != 3)});
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1357));
        rst_n = 1'b0; out_en = '1; cpu_en = 1'b1;
        pwr_dn = 1'b0; cpu_mode = 1'b1; park_z = 1'b0;
        m_run = '0; m_pair = 1; prev_run = '0;
        repeat (3) @(posedge clk_in);
        #1;
        // R9: reset state in the high phase of the clock
        chk("R9", {21'd0, clk_out, cpu_t, cpu_c, cpu_oe}, {21'd0, 8'd0, 1'b0, 1'b0, 1'b1});
        rst_n = 1'b1;
        // R9: no effect before the first falling edge after release
        chk("R9", 32'(clk_out), 32'(0));
        for (int k = 0; k < 600; k++) begin
            if (k < 4) begin
                // all enabled, running
                out_en = '1; cpu_en = 1'b1; pwr_dn = 1'b0;
            end else if (k < 8) begin
                out_en = 8'hA5; pwr_dn = 1'b1; cpu_mode = 1'b1; park_z = 1'b0;
            end else if (k < 12) begin
                pwr_dn = 1'b1; cpu_mode = 1'b1; park_z = 1'b1;
            end else if (k < 16) begin
                pwr_dn = 1'b1; cpu_mode = 1'b0; park_z = 1'b1;
            end else if (k < 20) begin
                pwr_dn = 1'b0; cpu_en = 1'b0; out_en = 8'h3C;
            end else if (k < 24) begin
                cpu_en = k[0]; out_en = k[0] ? 8'hFF : 8'h00;
            end else begin
                r = $urandom();
                out_en   = r[7:0];
                cpu_en   = r[8] | r[9];
                pwr_dn   = (r[11:10] == 2'b00);
                cpu_mode = r[12];
                park_z   = r[13];
            end
            @(negedge clk_in);
            #1;
            prev_run = m_run;
            m_run  = exp_run(pwr_dn, out_en);
            m_pair = exp_pair(pwr_dn, cpu_en, cpu_mode, park_z);
            check_low();
            @(posedge clk_in);
            #1;
            check_high();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule